// File: doc/BRIEF.md
# Unified pointer address converter

This block turns a 64-bit flat pointer issued by a shader memory operation into the 48-bit virtual address, translation-select bit and memory-type tag that the memory request path carries onward. For every valid request it first settles the addressing mode. The mode comes from a dispatch-level translation bit, a 32-bit-pointer configuration bit and a draw/compute indicator.

The block then checks the pointer against two programmable windows. The first is a GPUVM window: a hit there is rebased to the window start and sent to the driver-managed page tables. The second is an optional spare window that only changes the memory-type tag.

A pointer that lands in neither window takes the mode's default translation space. In the 64-bit modes, a non-canonical pointer that lands in neither window is flagged as falling into the address hole. Results appear one clock after the request, together with a valid strobe.

Top module: `uptr_conv`

## Requirements
- R1: The mode is decoded while `req_draw_i`=0. `cfg_dispatch_atc_i`=1 with `cfg_ptr32_i`=0 selects 64-bit IOMMU mode (HSA64). `cfg_dispatch_atc_i`=1 with `cfg_ptr32_i`=1 selects 32-bit IOMMU mode (HSA32). `cfg_dispatch_atc_i`=0 selects GPUVM64 mode whatever the value of `cfg_ptr32_i`.
- R2: A request with `req_draw_i`=1 is handled in GPUVM64 mode regardless of both configuration bits.
- R3: Each window's base is {register[47:0], 16'h0000} and its limit is {register[47:0], 16'hFFFF}. A pointer is inside a window when base <= pointer <= limit, with both ends included. A window whose enable input is 0 is never hit.
- R4: A pointer inside the enabled GPUVM window gives `rsp_atc_o`=0 and `rsp_addr_o` = (pointer - base)[47:0].
- R5: A pointer outside the GPUVM window gives `rsp_addr_o` = pointer[47:0]. Its `rsp_atc_o` is 1 in HSA64 and HSA32 modes and 0 in GPUVM64 mode.
- R6: In HSA32 mode only pointer bits [31:0] are used; bits [63:32] are taken as zero for every comparison and for the output address. `rsp_hole_o` is never set in this mode.
- R7: In the 64-bit modes, `rsp_hole_o`=1 exactly when pointer bits [63:47] are neither all zeros nor all ones and the pointer hits no window. When `rsp_hole_o`=1 the address is don't-care.
- R8: A hit in the enabled spare window, outside the GPUVM window, gives `rsp_mtype_o` = `spare_mtype_i`. Every other request gives `dflt_mtype_i`. The spare window is ignored in HSA32 mode.
- R9: Outputs are registered. `rsp_valid_o` equals `req_valid_i` of the previous cycle. Address, ATC, Mtype and hole outputs change only in the cycle after a valid request and otherwise hold. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ptr_i | input | 64 | Flat pointer |
| req_draw_i | input | 1 | Request comes from a draw (forces GPUVM64) |
| cfg_dispatch_atc_i | input | 1 | Dispatch default translation is IOMMU |
| cfg_ptr32_i | input | 1 | 32-bit pointer configuration |
| gpuvm_en_i | input | 1 | GPUVM window enable |
| gpuvm_base_i | input | 48 | GPUVM window base, pointer bits [63:16] |
| gpuvm_limit_i | input | 48 | GPUVM window limit, pointer bits [63:16] |
| spare_en_i | input | 1 | Spare window enable |
| spare_base_i | input | 48 | Spare window base, pointer bits [63:16] |
| spare_limit_i | input | 48 | Spare window limit, pointer bits [63:16] |
| spare_mtype_i | input | 2 | Mtype returned on a spare window hit |
| dflt_mtype_i | input | 2 | Default Mtype |
| rsp_valid_o | output | 1 | Result valid |
| rsp_addr_o | output | 48 | Converted virtual address |
| rsp_atc_o | output | 1 | 1 = IOMMU tables, 0 = GPUVM tables |
| rsp_mtype_o | output | 2 | Memory type tag |
| rsp_hole_o | output | 1 | Pointer fell in the non-canonical hole |

## Verification
The bench builds the block with its default parameters: 64-bit pointers, 48-bit addresses, 64 KB window granularity and 2-bit Mtype. With these values the hole test on bits [63:47] and the placement of the GPUVM window inside the hole (at 2^48, one terabyte wide) can be exercised with realistic pointers. The bench probes both inclusive edges of each window, and one step past each edge. The spare window is moved to the bottom 64 KB, so that a 32-bit pointer could reach it, which shows it being ignored in HSA32 mode while it still applies in HSA64 mode.

// File: rtl/uptr_conv_pkg.sv
package uptr_conv_pkg;
  typedef enum logic [1:0] {
    MODE_GPUVM64 = 2'd0,
    MODE_HSA64   = 2'd1,
    MODE_HSA32   = 2'd2
  } mode_e;
endpackage

// File: rtl/uptr_conv_mode_dec.sv
module uptr_conv_mode_dec
  import uptr_conv_pkg::*;
(
  input  logic  draw_i,
  input  logic  dispatch_atc_i,
  input  logic  ptr32_i,
  output mode_e mode_o
);
  always_comb begin
    if (draw_i || !dispatch_atc_i) mode_o = MODE_GPUVM64;
    else if (ptr32_i)              mode_o = MODE_HSA32;
    else                           mode_o = MODE_HSA64;
  end
endmodule

// File: rtl/uptr_conv_window.sv
module uptr_conv_window #(
  parameter int PTR_W   = 64,
  parameter int ALIGN_W = 16,
  localparam int REG_W  = PTR_W - ALIGN_W
) (
  input  logic             en_i,
  input  logic [REG_W-1:0] base_i,
  input  logic [REG_W-1:0] limit_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic             hit_o
);
  logic [PTR_W-1:0] lo, hi;
  assign lo    = {base_i, {ALIGN_W{1'b0}}};
  assign hi    = {limit_i, {ALIGN_W{1'b1}}};
  assign hit_o = en_i && (ptr_i >= lo) && (ptr_i <= hi);
endmodule

// File: rtl/uptr_conv_oreg.sv
module uptr_conv_oreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/uptr_conv.sv
module uptr_conv
  import uptr_conv_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int VA_W    = 48,
  parameter int ALIGN_W = 16,
  parameter int NARROW_W = 32,
  parameter int MT_W    = 2,
  localparam int REG_W  = PTR_W - ALIGN_W,
  localparam int RSP_W  = VA_W + MT_W + 2,
  localparam int NWIN   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PTR_W-1:0]  req_ptr_i,
  input  logic              req_draw_i,
  input  logic              cfg_dispatch_atc_i,
  input  logic              cfg_ptr32_i,
  input  logic              gpuvm_en_i,
  input  logic [REG_W-1:0]  gpuvm_base_i,
  input  logic [REG_W-1:0]  gpuvm_limit_i,
  input  logic              spare_en_i,
  input  logic [REG_W-1:0]  spare_base_i,
  input  logic [REG_W-1:0]  spare_limit_i,
  input  logic [MT_W-1:0]   spare_mtype_i,
  input  logic [MT_W-1:0]   dflt_mtype_i,
  output logic              rsp_valid_o,
  output logic [VA_W-1:0]   rsp_addr_o,
  output logic              rsp_atc_o,
  output logic [MT_W-1:0]   rsp_mtype_o,
  output logic              rsp_hole_o
);
  mode_e            mode;
  logic [PTR_W-1:0] eff_ptr;
  logic [NWIN-1:0]  win_en, win_hit;
  logic [NWIN-1:0][REG_W-1:0] win_base, win_limit;
  logic             gv_hit, sp_hit, canon, hole, atc;
  logic [VA_W-1:0]  gv_off, addr;
  logic [MT_W-1:0]  mtype;
  logic [RSP_W-1:0] rsp_d, rsp_q;

  uptr_conv_mode_dec u_mode (
    .draw_i         (req_draw_i),
    .dispatch_atc_i (cfg_dispatch_atc_i),
    .ptr32_i        (cfg_ptr32_i),
    .mode_o         (mode)
  );

  assign eff_ptr = (mode == MODE_HSA32)
                 ? {{(PTR_W-NARROW_W){1'b0}}, req_ptr_i[NARROW_W-1:0]}
                 : req_ptr_i;

  // window 0: GPUVM, window 1: spare (not usable in 32-bit mode)
  assign win_en    = {spare_en_i && (mode != MODE_HSA32), gpuvm_en_i};
  assign win_base  = {spare_base_i, gpuvm_base_i};
  assign win_limit = {spare_limit_i, gpuvm_limit_i};

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    uptr_conv_window #(.PTR_W(PTR_W), .ALIGN_W(ALIGN_W)) u_win (
      .en_i    (win_en[g]),
      .base_i  (win_base[g]),
      .limit_i (win_limit[g]),
      .ptr_i   (eff_ptr),
      .hit_o   (win_hit[g])
    );
  end

  // GPUVM has priority; windows are not expected to overlap
  assign gv_hit = win_hit[0];
  assign sp_hit = win_hit[1] && !gv_hit;

  assign canon = (&eff_ptr[PTR_W-1:VA_W-1]) || !(|eff_ptr[PTR_W-1:VA_W-1]);
  assign hole  = (mode != MODE_HSA32) && !canon && !gv_hit && !sp_hit;

  assign gv_off = eff_ptr[VA_W-1:0] - {gpuvm_base_i[VA_W-ALIGN_W-1:0], {ALIGN_W{1'b0}}};
  assign addr   = gv_hit ? gv_off : eff_ptr[VA_W-1:0];
  assign atc    = !gv_hit && (mode != MODE_GPUVM64);
  assign mtype  = sp_hit ? spare_mtype_i : dflt_mtype_i;

  assign rsp_d = {addr, atc, mtype, hole};

  uptr_conv_oreg #(.W(RSP_W)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (req_valid_i),
    .d_i    (rsp_d),
    .vld_o  (rsp_valid_o),
    .q_o    (rsp_q)
  );

  assign {rsp_addr_o, rsp_atc_o, rsp_mtype_o, rsp_hole_o} = rsp_q;
endmodule

// File: rtl/uptr_conv_chk.sv
module uptr_conv_chk #(
  parameter int PTR_W    = 64,
  parameter int VA_W     = 48,
  parameter int NARROW_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [PTR_W-1:0] req_ptr_i,
  input logic             req_draw_i,
  input logic             cfg_dispatch_atc_i,
  input logic             cfg_ptr32_i,
  input logic             rsp_valid_o,
  input logic [VA_W-1:0]  rsp_addr_o,
  input logic             rsp_atc_o,
  input logic             rsp_hole_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  logic canon_in, narrow_in;
  assign canon_in  = (&req_ptr_i[PTR_W-1:VA_W-1]) || !(|req_ptr_i[PTR_W-1:VA_W-1]);
  assign narrow_in = !req_draw_i && cfg_dispatch_atc_i && cfg_ptr32_i;

  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    rsp_valid_o == $past(req_valid_i));

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$past(req_valid_i) |-> $stable(rsp_addr_o) && $stable(rsp_atc_o) && $stable(rsp_hole_o));

  // R2
  draw_gpuvm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(req_valid_i && req_draw_i) |-> !rsp_atc_o);

  // R1
  gpuvm_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(req_valid_i && !cfg_dispatch_atc_i) |-> !rsp_atc_o);

  // R6
  narrow_no_hole_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(req_valid_i && narrow_in) |-> !rsp_hole_o && (rsp_addr_o[VA_W-1:NARROW_W] == '0));

  // R7
  canon_no_hole_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(req_valid_i && canon_in) |-> !rsp_hole_o);
endmodule

bind uptr_conv uptr_conv_chk #(.PTR_W(PTR_W), .VA_W(VA_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/uptr_conv_test.sv
module uptr_conv_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] req_ptr_i = '0;
  logic        req_draw_i = 1'b0;
  logic        cfg_dispatch_atc_i = 1'b0;
  logic        cfg_ptr32_i = 1'b0;
  logic        gpuvm_en_i = 1'b1;
  logic [47:0] gpuvm_base_i  = 48'h0001_0000_0000;
  logic [47:0] gpuvm_limit_i = 48'h0001_00FF_FFFF;
  logic        spare_en_i = 1'b1;
  logic [47:0] spare_base_i  = 48'h0000_1000_0000;
  logic [47:0] spare_limit_i = 48'h0000_1000_FFFF;
  logic [1:0]  spare_mtype_i = 2'd3;
  logic [1:0]  dflt_mtype_i  = 2'd1;
  logic        rsp_valid_o;
  logic [47:0] rsp_addr_o;
  logic        rsp_atc_o;
  logic [1:0]  rsp_mtype_o;
  logic        rsp_hole_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uptr_conv uut (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        draw;
    logic        datc;
    logic        p32;
    logic [63:0] ptr;
    logic [47:0] addr;
    logic        atc;
    logic [1:0]  mt;
    logic        hole;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R4 GPUVM window interior, HSA64
    '{4'd4, 1'b0, 1'b1, 1'b0, 64'h0001_0000_1234_5678, 48'h0000_1234_5678, 1'b0, 2'd1, 1'b0},
    // R3 GPUVM base inclusive
    '{4'd3, 1'b0, 1'b1, 1'b0, 64'h0001_0000_0000_0000, 48'h0000_0000_0000, 1'b0, 2'd1, 1'b0},
    // R3 GPUVM limit inclusive
    '{4'd3, 1'b0, 1'b1, 1'b0, 64'h0001_00FF_FFFF_FFFF, 48'h00FF_FFFF_FFFF, 1'b0, 2'd1, 1'b0},
    // R7 limit+1 lands in hole
    '{4'd7, 1'b0, 1'b1, 1'b0, 64'h0001_0100_0000_0000, 48'h0, 1'b1, 2'd1, 1'b1},
    // R7 base-1 lands in hole
    '{4'd7, 1'b0, 1'b1, 1'b0, 64'h0000_FFFF_FFFF_FFFF, 48'h0, 1'b1, 2'd1, 1'b1},
    // R5 low canonical, HSA64 default IOMMU
    '{4'd5, 1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_4000, 48'h0000_0000_4000, 1'b1, 2'd1, 1'b0},
    // R5 high canonical
    '{4'd5, 1'b0, 1'b1, 1'b0, 64'hFFFF_8000_0000_0010, 48'h8000_0000_0010, 1'b1, 2'd1, 1'b0},
    // R8 spare interior
    '{4'd8, 1'b0, 1'b1, 1'b0, 64'h0000_1000_0000_0040, 48'h1000_0000_0040, 1'b1, 2'd3, 1'b0},
    // R8 spare limit inclusive
    '{4'd8, 1'b0, 1'b1, 1'b0, 64'h0000_1000_FFFF_FFFF, 48'h1000_FFFF_FFFF, 1'b1, 2'd3, 1'b0},
    // R8 spare limit+1
    '{4'd8, 1'b0, 1'b1, 1'b0, 64'h0000_1001_0000_0000, 48'h1001_0000_0000, 1'b1, 2'd1, 1'b0},
    // R6 HSA32 drops upper bits, no hole
    '{4'd6, 1'b0, 1'b1, 1'b1, 64'hDEAD_0000_1000_0040, 48'h0000_1000_0040, 1'b1, 2'd1, 1'b0},
    // R1 GPUVM64 default space
    '{4'd1, 1'b0, 1'b0, 1'b0, 64'h0000_0000_ABCD_0000, 48'h0000_ABCD_0000, 1'b0, 2'd1, 1'b0},
    // R1 ptr32 ignored when dispatch ATC is 0
    '{4'd1, 1'b0, 1'b0, 1'b1, 64'hDEAD_0000_1000_0040, 48'h0, 1'b0, 2'd1, 1'b1},
    // R2 draw forces GPUVM64
    '{4'd2, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_4000, 48'h0000_0000_4000, 1'b0, 2'd1, 1'b0},
    // R2 draw overrides ptr32
    '{4'd2, 1'b1, 1'b1, 1'b1, 64'hDEAD_0000_1000_0040, 48'h0, 1'b0, 2'd1, 1'b1},
    // R4 GPUVM hit in GPUVM64
    '{4'd4, 1'b0, 1'b0, 1'b0, 64'h0001_0000_0000_0100, 48'h0000_0000_0100, 1'b0, 2'd1, 1'b0},
    // R8 spare hit in GPUVM64
    '{4'd8, 1'b0, 1'b0, 1'b0, 64'h0000_1000_0000_0040, 48'h1000_0000_0040, 1'b0, 2'd3, 1'b0}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic draw, logic datc, logic p32, logic [63:0] ptr);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_draw_i = draw;
    cfg_dispatch_atc_i = datc;
    cfg_ptr32_i = p32;
    req_ptr_i = ptr;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  initial begin
    logic [47:0] held;
    // R9 reset state
    repeat (2) @(negedge clk_i);
    chk("R9 reset valid", {63'b0, rsp_valid_o}, 64'd0);
    chk("R9 reset addr", {16'b0, rsp_addr_o}, 64'd0);
    chk("R9 reset atc/mt/hole", {60'b0, rsp_atc_o, rsp_mtype_o, rsp_hole_o}, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VECS[i];
      send(v.draw, v.datc, v.p32, v.ptr);
      t = $sformatf("R%0d vec%0d", v.req, i);
      chk({t, " valid"}, {63'b0, rsp_valid_o}, 64'd1);
      chk({t, " atc"}, {63'b0, rsp_atc_o}, {63'b0, v.atc});
      chk({t, " mtype"}, {62'b0, rsp_mtype_o}, {62'b0, v.mt});
      chk({t, " hole"}, {63'b0, rsp_hole_o}, {63'b0, v.hole});
      if (!v.hole) chk({t, " addr"}, {16'b0, rsp_addr_o}, {16'b0, v.addr});
    end

    // R9 valid drops and outputs hold without a request
    held = rsp_addr_o;
    @(negedge clk_i);
    req_ptr_i = 64'h0001_0000_0000_0F00;
    cfg_dispatch_atc_i = 1'b1;
    cfg_ptr32_i = 1'b0;
    req_draw_i = 1'b0;
    @(negedge clk_i);
    chk("R9 valid low", {63'b0, rsp_valid_o}, 64'd0);
    chk("R9 addr held", {16'b0, rsp_addr_o}, {16'b0, held});

    // R8 spare window reachable by a 32-bit pointer, but ignored in HSA32
    spare_base_i  = 48'h0;
    spare_limit_i = 48'h0;
    send(1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_0040);
    chk("R8 spare ignored HSA32", {62'b0, rsp_mtype_o}, 64'd1);
    chk("R6 HSA32 addr", {16'b0, rsp_addr_o}, 64'h40);
    send(1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_0040);
    chk("R8 spare used HSA64", {62'b0, rsp_mtype_o}, 64'd3);
    // R3 disabled windows are never hit
    spare_en_i = 1'b0;
    gpuvm_en_i = 1'b0;
    send(1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_0040);
    chk("R3 spare disabled", {62'b0, rsp_mtype_o}, 64'd1);
    send(1'b0, 1'b1, 1'b0, 64'h0001_0000_0000_0100);
    chk("R3 gpuvm disabled hole", {63'b0, rsp_hole_o}, 64'd1);
    chk("R5 gpuvm disabled atc", {63'b0, rsp_atc_o}, 64'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule